// File: doc/BRIEF.md
# Hash Message Expansion Stage Two

This datapath finishes one four-word step of the SM3 message schedule. It takes three 128-bit operands. The first holds the four partial words that the first expansion stage produced. The second holds the earlier schedule words W3..W6. The third holds W10..W13. From these it forms the finished words W16..W19 and returns them in one 128-bit result.

Each of the first three output words is built from its own lane alone. The fourth word needs one more correction, which is based on the first output word of the same operation. That correction creates a short dependency chain inside the datapath. The adder-free logic sits in front of an output register. A valid/ready handshake controls the register, so a result appears one cycle after it is accepted. While the consumer stalls, the result is held.

Top module: `msx2_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: For lanes k = 0, 1, 2, where lane k is bits [32k+31:32k] of each operand and of the result, result lane k equals rotl(`prev_lo` lane k, 7) XOR `prev_hi` lane k XOR `mid_words` lane k. Here rotl is a 32-bit left rotation with the amount taken modulo 32.
- R3: Result lane 3 equals the preliminary value rotl(`prev_lo` lane 3, 7) XOR `prev_hi` lane 3 XOR `mid_words` lane 3, XORed with result lane 0 rotated left by 6, by 15 and by 30.
- R4: Result lanes 0, 1, 2 and 3 carry W16, W17, W18 and W19 in that order. For example, `mid_words` = 1 with all other inputs 0 gives lane 0 = 0x00000001, lanes 1 and 2 = 0, and lane 3 = 0x40008040.
- R5: `in_ready` is 1 exactly when `out_valid` is 0 or `out_ready` is 1.
- R6: An operand set accepted on a clock edge (`in_valid` and `in_ready` both 1) is presented on `sched_out` with `out_valid` = 1 after that edge.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `sched_out` does not change.
- R8: Operand values offered with `in_valid` = 1 while `in_ready` is 0 have no effect on the held result or on later results.
- R9: When a result is consumed and no new operand set is accepted on the same edge, `out_valid` goes to 0.
- R10: With `out_ready` held at 1, one operand set is accepted every cycle, and results emerge in acceptance order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Operand set can be taken this cycle |
| mid_words | input | 128 | Four partial words from the first expansion stage |
| prev_lo | input | 128 | Schedule words W3..W6, lanes 0..3 |
| prev_hi | input | 128 | Schedule words W10..W13, lanes 0..3 |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| sched_out | output | 128 | Finished words W16..W19, lanes 0..3 |

## Verification
The assertions check the handshake contract on every cycle. These checks cover the response to reset, the one-cycle step from acceptance to a valid output, the holding of data during a stall, and the drop of the valid flag after draining. The values of the words can only be shown by the bench's scenarios. In those scenarios, a behavioural first stage is chained into the block over whole 512-bit blocks and compared with a full schedule expansion. The scenarios also use directed single-bit vectors that isolate the lane-3 correction, and they offer junk operands during stalls to show that those operands are ignored.

// File: rtl/msx2_pkg.sv
package msx2_pkg;

   // Width of one schedule word; the message schedule is defined on 32-bit words.
   localparam int unsigned WORD_W = 32;

   typedef logic [WORD_W-1:0] word_t;

   // Left rotation of a word; the amount is reduced modulo the word width.
   function automatic word_t rotl(input word_t x, input int unsigned amt);
      int unsigned a;
      a = amt % WORD_W;
      if (a == 0) return x;
      return (x << a) | (x >> (WORD_W - a));
   endfunction

endpackage

// File: rtl/msx2_lane.sv
// One lane of the preliminary combine: rotated older word, newer word, partial word.
module msx2_lane
   import msx2_pkg::*;
#(
   parameter int unsigned ROT_LO = 7
) (
   input  word_t part_in,
   input  word_t lo_in,
   input  word_t hi_in,
   output word_t pre_out
);

   initial begin
      if (ROT_LO >= WORD_W) $error("msx2_lane: ROT_LO out of range");
   end

   word_t lo_rot;

   always_comb begin
      lo_rot  = rotl(lo_in, ROT_LO);
      pre_out = lo_rot ^ hi_in ^ part_in;
   end

endmodule

// File: rtl/msx2_fixup.sv
// Correction of the last lane using the freshly formed first lane.
module msx2_fixup
   import msx2_pkg::*;
#(
   parameter int unsigned ROT_A = 6,
   parameter int unsigned ROT_B = 15,
   parameter int unsigned ROT_C = 30
) (
   input  word_t seed_in,
   input  word_t pre_in,
   output word_t fix_out
);

   initial begin
      if (ROT_A >= WORD_W || ROT_B >= WORD_W || ROT_C >= WORD_W)
         $error("msx2_fixup: rotation amount out of range");
   end

   word_t mix;

   always_comb begin
      mix     = rotl(seed_in, ROT_A) ^ rotl(seed_in, ROT_B) ^ rotl(seed_in, ROT_C);
      fix_out = pre_in ^ mix;
   end

endmodule

// File: rtl/msx2_outreg.sv
// Single result register with valid/ready flow control.
module msx2_outreg #(
   parameter int unsigned DATA_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data
);

   initial begin
      if (DATA_W == 0) $error("msx2_outreg: DATA_W must be positive");
   end

   logic              vld_q;
   logic [DATA_W-1:0] dat_q;
   logic              take;

   always_comb begin
      in_ready = !vld_q || out_ready;
      take     = in_valid && in_ready;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
      end else if (take) begin
         vld_q <= 1'b1;
      end else if (out_ready) begin
         vld_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dat_q <= '0;
      end else if (take) begin
         dat_q <= in_data;
      end
   end

   assign out_valid = vld_q;
   assign out_data  = dat_q;

   // R1
   reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

   // R5
   stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   // R6
   accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   // R7
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R9
   drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !in_valid) |=> !out_valid);

endmodule

// File: rtl/msx2_top.sv
module msx2_top
   import msx2_pkg::*;
#(
   parameter int unsigned LANES  = 4,
   parameter int unsigned ROT_LO = 7,
   parameter int unsigned ROT_A  = 6,
   parameter int unsigned ROT_B  = 15,
   parameter int unsigned ROT_C  = 30
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [127:0] mid_words,
   input  logic [127:0] prev_lo,
   input  logic [127:0] prev_hi,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [127:0] sched_out
);

   localparam int unsigned VEC_W = LANES * WORD_W;
   localparam int unsigned LAST  = LANES - 1;

   initial begin
      if (LANES != 4)   $error("msx2_top: LANES must be 4");
      if (VEC_W != 128) $error("msx2_top: vector width must be 128");
   end

   word_t [LANES-1:0] pre;
   word_t [LANES-1:0] fin;

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         msx2_lane #(.ROT_LO(ROT_LO)) i_lane (
            .part_in (mid_words[k*WORD_W +: WORD_W]),
            .lo_in   (prev_lo  [k*WORD_W +: WORD_W]),
            .hi_in   (prev_hi  [k*WORD_W +: WORD_W]),
            .pre_out (pre[k])
         );
         if (k == LAST) begin : g_fix
            msx2_fixup #(.ROT_A(ROT_A), .ROT_B(ROT_B), .ROT_C(ROT_C)) i_fix (
               .seed_in (pre[0]),
               .pre_in  (pre[k]),
               .fix_out (fin[k])
            );
         end else begin : g_pass
            assign fin[k] = pre[k];
         end
      end
   endgenerate

   logic [VEC_W-1:0] result;
   assign result = fin;

   msx2_outreg #(.DATA_W(VEC_W)) i_oreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (result),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (sched_out)
   );

endmodule

// File: tb/test_msx2_top.sv
module test_msx2_top;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid;
   logic         in_ready;
   logic [127:0] mid_words, prev_lo, prev_hi;
   logic         out_valid;
   logic         out_ready;
   logic [127:0] sched_out;

   always #10 clk = ~clk;

   msx2_top i_msx2_top (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .mid_words(mid_words), .prev_lo(prev_lo), .prev_hi(prev_hi),
      .out_valid(out_valid), .out_ready(out_ready), .sched_out(sched_out)
   );

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   logic [127:0] pend_a[$], pend_b[$], pend_c[$], pend_e[$];
   logic [127:0] expq[$];

   function automatic logic [31:0] rl(input logic [31:0] x, input int n);
      int m;
      m = n % 32;
      if (m == 0) return x;
      return (x << m) | (x >> (32 - m));
   endfunction

   function automatic logic [31:0] p1(input logic [31:0] x);
      return x ^ rl(x, 15) ^ rl(x, 23);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Full schedule of one block, then stage-one partials fed to the block.
   task automatic add_block(input int seed);
      logic [31:0] w[68];
      logic [127:0] a, b, c, e;
      for (int i = 0; i < 16; i++) w[i] = 32'h9E3779B9 * (seed + 1) ^ (32'h01000193 * i) ^ seed;
      if (seed == 0) for (int i = 0; i < 16; i++) w[i] = '0;
      if (seed == 1) for (int i = 0; i < 16; i++) w[i] = '1;
      for (int j = 16; j < 68; j++)
         w[j] = p1(w[j-16] ^ w[j-9] ^ rl(w[j-3], 15)) ^ rl(w[j-13], 7) ^ w[j-6];
      for (int j = 16; j < 68; j += 4) begin
         for (int i = 0; i < 4; i++) begin
            if (i < 3) a[32*i +: 32] = p1(w[j-16+i] ^ w[j-9+i] ^ rl(w[j-3+i], 15));
            else       a[32*i +: 32] = p1(w[j-16+i] ^ w[j-9+i]);
            b[32*i +: 32] = w[j-13+i];
            c[32*i +: 32] = w[j-6+i];
            e[32*i +: 32] = w[j+i];
         end
         pend_a.push_back(a); pend_b.push_back(b); pend_c.push_back(c); pend_e.push_back(e);
      end
   endtask

   task automatic add_vec(input logic [127:0] a, b, c, e);
      pend_a.push_back(a); pend_b.push_back(b); pend_c.push_back(c); pend_e.push_back(e);
   endtask

   // mode 0: consumer always ready, producer always offers (R10)
   // mode 1: irregular ready and valid with junk offered during stalls (R7, R8)
   task automatic run(input int mode);
      int guard = 0;
      bit stall;
      while ((pend_a.size() > 0 || expq.size() > 0) && guard < 5000) begin
         guard++;
         @(negedge clk);
         cyc++;
         out_ready = (mode == 0) ? 1'b1 : ((cyc % 5) != 2 && (cyc % 7) != 3);
         stall = (expq.size() > 0) && !out_ready;
         if (stall) begin
            in_valid  = 1'b1;
            mid_words = {4{32'hDEADBEEF}} ^ {cyc, cyc, cyc, cyc};
            prev_lo   = ~mid_words;
            prev_hi   = {4{32'h5A5AA5A5}};
         end else if (pend_a.size() > 0 && (mode == 0 || (cyc % 6) != 4)) begin
            in_valid  = 1'b1;
            mid_words = pend_a[0];
            prev_lo   = pend_b[0];
            prev_hi   = pend_c[0];
         end else begin
            in_valid  = 1'b0;
            mid_words = '1;
            prev_lo   = '1;
            prev_hi   = '1;
         end
         #1;
         chk(out_valid == (expq.size() != 0), "R6/R9 out_valid",
             {127'd0, out_valid}, {127'd0, expq.size() != 0});
         if (out_valid && expq.size() != 0)
            chk(sched_out === expq[0], "R2/R3/R4/R7/R8 result", sched_out, expq[0]);
         chk(in_ready == ((expq.size() == 0) || out_ready), "R5 in_ready",
             {127'd0, in_ready}, {127'd0, (expq.size() == 0) || out_ready});
         if (mode == 0)
            chk(in_ready == 1'b1, "R10 throughput", {127'd0, in_ready}, 128'd1);
         if (out_valid && out_ready && expq.size() != 0) void'(expq.pop_front());
         if (in_valid && in_ready && !stall && pend_a.size() > 0) begin
            expq.push_back(pend_e.pop_front());
            void'(pend_a.pop_front()); void'(pend_b.pop_front()); void'(pend_c.pop_front());
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
      mid_words = '0; prev_lo = '0; prev_hi = '0;
      repeat (3) @(negedge clk);
      chk(!out_valid && in_ready, "R1 during reset", {126'd0, out_valid, in_ready}, 128'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!out_valid && in_ready, "R1 after reset", {126'd0, out_valid, in_ready}, 128'd1);

      // R3 / R4: isolated first-lane bit drives the lane-3 correction
      add_vec(128'h1, '0, '0, {32'h40008040, 32'h0, 32'h0, 32'h1});
      // R2: rotation by 7 wraps the top bit of lane 1
      add_vec('0, {32'h0, 32'h0, 32'h80000000, 32'h0}, '0, {32'h0, 32'h0, 32'h40, 32'h0});
      // R2 / R3: lane 3 without first-lane influence
      add_vec({32'h12345678, 96'd0}, {32'h00000001, 96'd0}, {32'h0F0F0000, 96'd0},
              {32'h12345678 ^ 32'h80 ^ 32'h0F0F0000, 96'd0});
      run(0);

      add_block(0);
      add_block(1);
      add_block(2);
      run(0);

      add_block(3);
      add_block(4);
      add_block(5);
      run(1);

      // R9: after draining, valid stays low with nothing offered
      repeat (2) @(negedge clk);
      chk(!out_valid, "R9 idle after drain", {127'd0, out_valid}, 128'd0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule